// File: doc/BRIEF.md
# Audio Playback Transmit Path

This block is the digital front end of an audio DAC's playback channel. A host or DMA engine writes samples through a 32-bit register port into a 64-entry transmit FIFO. A request line asks the DMA engine for more data. It rises when the free space in the FIFO goes above a programmed trigger level. It falls again only when the free space drops under a separate, lower clear level. A divider on the module clock produces one frame tick per output frame, at a rate chosen by a 3-bit code.

On each frame tick the block takes one whole frame from the FIFO and widens it to 24 bits. It then presents the frame as a left and right sample pair with a one-cycle valid strobe. There are two input widths. In 16-bit mode one word carries a stereo pair and the short samples are widened to 24 bits. In 24-bit mode each word carries a single sample, MSB-aligned. Mono mode sends one sample to both outputs.

When a frame is not available at a tick, the block outputs either silence or the last frame, as programmed. It also sets a sticky flag in the status register. The FIFO can be flushed by writing the control register.

Top module: `audio_tx_path`

## Requirements
- R1: Reads are combinational. Offset 0x04 returns the stored control fields, masked by 0xE5603F70, with bit 0 always reading 0. Offset 0x08 returns the free-slot count in bits [6:0] and the underrun flag in bit 8. Every other offset, including the data port at 0x0C, reads 0.
- R2: A control write with bit 0 set empties the FIFO at that clock edge, so the free count reads 64 on the next cycle. Any other fields in the same write still take effect.
- R3: Each write to offset 0x0C pushes the 32-bit word into the FIFO. A write while the free count is 0 is dropped.
- R4: The DMA request becomes 1 one cycle after the control enable bit 4 is 1 and the free count is greater than the trigger level in control bits [13:8].
- R5: The DMA request becomes 0 one cycle after bit 4 is cleared, or after the free count drops below 4*(N+1), where N is control bits [22:21]. While the free count lies between the clear level and the trigger level, the request keeps its previous state.
- R6: The rate code in control bits [31:29] sets the frame period in clocks. Codes 0 to 7 give 256, 384, 512, 768, 1024, 1536, 64 and 128 respectively. The valid strobe is high for one cycle per period.
- R7: In 16-bit stereo mode (bit 5 = 0, bit 6 = 0) one word is one frame. The left sample comes from word bits [15:0] and the right sample from bits [31:16].
- R8: Control bit 24 selects how a 16-bit sample h is widened. With 0 the result is {h, 8'h00}. With 1 the result is {h, 8 copies of h[15]}.
- R9: In 24-bit mode (bit 5 = 1) a sample is word bits [31:8]. In stereo, one frame takes two words, the left word first.
- R10: In mono mode (bit 6 = 1) one word is one frame and both outputs carry the same sample. In 16-bit mono that sample is bits [15:0].
- R11: A tick that finds less than a full frame in the FIFO pops nothing and sets the status bit 8 flag. With control bit 26 = 0 it outputs zero on both channels.
- R12: With control bit 26 = 1, an underrun tick repeats the last frame that was taken from the FIFO.
- R13: Writing offset 0x08 with bit 8 set clears the underrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| drq_o | output | 1 | DMA request |
| smp_l_o | output | 24 | Left output sample |
| smp_r_o | output | 24 | Right output sample |
| smp_vld_o | output | 1 | Sample pair valid, one cycle per frame |

## Verification
Register reads are due in the same cycle as the address. A control or data write changes the FIFO count and the control fields at the edge where the write is taken. The DMA request follows one edge after that. A frame tick updates the samples, the valid strobe and the underrun flag at a single edge. The bench drives every input and reads every output at falling edges. It checks the request one full cycle after each write. It takes samples in the very half-cycle where the valid strobe is seen high, and it starts refilling right after a strobe so that all writes land before the next tick.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DATA = 6'h0C;

  typedef struct packed {
    logic [2:0] rate;
    logic       hold_last;
    logic       rep_msb;
    logic [1:0] clr_cnt;
    logic [5:0] trig;
    logic       mono;
    logic       wide;
    logic       drq_en;
  } ctrl_t;

  // frame period in clocks for a rate code, base = clocks at code 0
  function automatic int unsigned rate_div(input logic [2:0] code, input int unsigned base);
    case (code)
      3'd0: rate_div = base;
      3'd1: rate_div = (base * 3) / 2;
      3'd2: rate_div = base * 2;
      3'd3: rate_div = base * 3;
      3'd4: rate_div = base * 4;
      3'd5: rate_div = base * 6;
      3'd6: rate_div = base / 4;
      default: rate_div = base / 2;
    endcase
  endfunction
endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,   // power of two
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    pop_cnt_i,
  output logic [DW-1:0] rd0_o,
  output logic [DW-1:0] rd1_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push;

  assign do_push = push_i && (cnt_q < CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + AW'(1);
      rptr_q <= rptr_q + AW'(pop_cnt_i);
      cnt_q  <= cnt_q + CW'(do_push) - CW'(pop_cnt_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rd0_o = mem_q[rptr_q];
  assign rd1_o = mem_q[rptr_q + AW'(1)];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/atx_rate_tick.sv
module atx_rate_tick
  import audio_tx_pkg::*;
#(
  parameter int BASE_CLKS = 256,
  localparam int CNT_W    = $clog2(BASE_CLKS * 6)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] rate_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q, lim;

  assign lim    = CNT_W'(rate_div(rate_i, BASE_CLKS) - 1);
  // >= so that a shorter period after a rate change ends at once
  assign tick_o = cnt_q >= lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/atx_fmt.sv
module atx_fmt (
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  input  logic        wide_i,
  input  logic        mono_i,
  input  logic        rep_msb_i,
  output logic [23:0] l_o,
  output logic [23:0] r_o,
  output logic [1:0]  need_o
);
  function automatic logic [23:0] widen(input logic [15:0] h, input logic rep);
    widen = rep ? {h, {8{h[15]}}} : {h, 8'h00};
  endfunction

  logic unused_w1_lsb;
  assign unused_w1_lsb = ^w1_i[7:0];

  always_comb begin
    need_o = 2'd1;
    if (wide_i) begin
      l_o = w0_i[31:8];
      r_o = mono_i ? w0_i[31:8] : w1_i[31:8];
      if (!mono_i) need_o = 2'd2;
    end else begin
      l_o = widen(w0_i[15:0], rep_msb_i);
      r_o = mono_i ? widen(w0_i[15:0], rep_msb_i) : widen(w0_i[31:16], rep_msb_i);
    end
  end
endmodule

// File: rtl/atx_drq.sv
module atx_drq #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [5:0]    trig_i,
  input  logic [1:0]    clr_cnt_i,
  input  logic [CW-1:0] free_i,
  output logic          drq_o
);
  logic [CW-1:0] clr_thr;
  logic          drq_q;

  assign clr_thr = CW'({clr_cnt_i, 2'b00}) + CW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    drq_q <= 1'b0;
    else if (!en_i)                 drq_q <= 1'b0;
    else if (free_i < clr_thr)      drq_q <= 1'b0;
    else if (free_i > CW'(trig_i))  drq_q <= 1'b1;
  end

  assign drq_o = drq_q;
endmodule

// File: rtl/audio_tx_path.sv
module audio_tx_path
  import audio_tx_pkg::*;
#(
  parameter int DEPTH     = 64,   // power of two, at most 128
  parameter int BASE_CLKS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              drq_o,
  output logic [23:0]       smp_l_o,
  output logic [23:0]       smp_r_o,
  output logic              smp_vld_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  ctrl_t         ctrl_q;
  logic          under_q;
  logic          wr_ctrl, wr_stat, wr_data, flush_wr;
  logic [31:0]   rd0, rd1;
  logic [CW-1:0] fifo_cnt, free_cnt;
  logic [23:0]   fl, fr, last_l_q, last_r_q;
  logic [1:0]    need, pop_cnt;
  logic          tick, enough;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == OFF_CTRL);
  assign wr_stat  = reg_we_i && (reg_addr_i == OFF_STAT);
  assign wr_data  = reg_we_i && (reg_addr_i == OFF_DATA);
  assign flush_wr = wr_ctrl && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.rate      <= reg_wdata_i[31:29];
      ctrl_q.hold_last <= reg_wdata_i[26];
      ctrl_q.rep_msb   <= reg_wdata_i[24];
      ctrl_q.clr_cnt   <= reg_wdata_i[22:21];
      ctrl_q.trig      <= reg_wdata_i[13:8];
      ctrl_q.mono      <= reg_wdata_i[6];
      ctrl_q.wide      <= reg_wdata_i[5];
      ctrl_q.drq_en    <= reg_wdata_i[4];
    end
  end

  atx_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(flush_wr), .push_i(wr_data), .wdata_i(reg_wdata_i),
    .pop_cnt_i(pop_cnt), .rd0_o(rd0), .rd1_o(rd1), .cnt_o(fifo_cnt)
  );

  assign free_cnt = CW'(DEPTH) - fifo_cnt;

  atx_rate_tick #(.BASE_CLKS(BASE_CLKS)) u_tick (
    .clk_i, .rst_ni, .rate_i(ctrl_q.rate), .tick_o(tick)
  );

  atx_fmt u_fmt (
    .w0_i(rd0), .w1_i(rd1), .wide_i(ctrl_q.wide), .mono_i(ctrl_q.mono),
    .rep_msb_i(ctrl_q.rep_msb), .l_o(fl), .r_o(fr), .need_o(need)
  );

  // a frame is taken whole or not at all
  assign enough  = (fifo_cnt >= CW'(need)) && !flush_wr;
  assign pop_cnt = (tick && enough) ? need : 2'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_l_o   <= '0;
      smp_r_o   <= '0;
      smp_vld_o <= 1'b0;
      last_l_q  <= '0;
      last_r_q  <= '0;
    end else begin
      smp_vld_o <= tick;
      if (tick) begin
        if (enough) begin
          smp_l_o  <= fl;
          smp_r_o  <= fr;
          last_l_q <= fl;
          last_r_q <= fr;
        end else begin
          smp_l_o <= ctrl_q.hold_last ? last_l_q : '0;
          smp_r_o <= ctrl_q.hold_last ? last_r_q : '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       under_q <= 1'b0;
    else if (tick && !enough)          under_q <= 1'b1;
    else if (wr_stat && reg_wdata_i[8]) under_q <= 1'b0;
  end

  atx_drq #(.CW(CW)) u_drq (
    .clk_i, .rst_ni, .en_i(ctrl_q.drq_en), .trig_i(ctrl_q.trig),
    .clr_cnt_i(ctrl_q.clr_cnt), .free_i(free_cnt), .drq_o(drq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_CTRL: begin
        reg_rdata_o[31:29] = ctrl_q.rate;
        reg_rdata_o[26]    = ctrl_q.hold_last;
        reg_rdata_o[24]    = ctrl_q.rep_msb;
        reg_rdata_o[22:21] = ctrl_q.clr_cnt;
        reg_rdata_o[13:8]  = ctrl_q.trig;
        reg_rdata_o[6]     = ctrl_q.mono;
        reg_rdata_o[5]     = ctrl_q.wide;
        reg_rdata_o[4]     = ctrl_q.drq_en;
      end
      OFF_STAT: begin
        reg_rdata_o[CW-1:0] = free_cnt;
        reg_rdata_o[8]      = under_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/audio_tx_path_chk.sv
module audio_tx_path_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vld,
  input logic          tick,
  input logic          drq,
  input logic          drq_en,
  input logic          flush_wr,
  input logic [CW-1:0] free_cnt
);
  a_r6_vld_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |=> !vld);

  a_r6_vld_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld) |-> $past(tick));

  a_r5_drq_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drq_en |=> !drq);

  a_r2_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_wr |=> (free_cnt == CW'(DEPTH)));

  a_r3_free_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt <= CW'(DEPTH));
endmodule

bind audio_tx_path audio_tx_path_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vld(smp_vld_o), .tick(tick), .drq(drq_o),
  .drq_en(ctrl_q.drq_en), .flush_wr(flush_wr), .free_cnt(free_cnt)
);

// File: tb/sim_audio_tx_path.sv
module sim_audio_tx_path;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic        drq, vld;
  logic [23:0] sl, sr;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  audio_tx_path u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .drq_o(drq),
    .smp_l_o(sl), .smp_r_o(sr), .smp_vld_o(vld)
  );

  function automatic int exp_div(input int code);
    case (code)
      0: return 256;  1: return 384;  2: return 512;  3: return 768;
      4: return 1024; 5: return 1536; 6: return 64;   default: return 128;
    endcase
  endfunction

  function automatic logic [23:0] widen(input logic [15:0] h, input bit rep);
    return rep ? {h, {8{h[15]}}} : {h, 8'h00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #2;
    d = rdata;
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) wr(6'h0C, $urandom);
  endtask

  task automatic wait_vld();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!vld && n < 4000);
    if (!vld) chk(1'b0, "R6 strobe timeout", 32'(n), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, cfg, w0, w1;
    logic [23:0] el [10];
    logic [23:0] er [10];
    logic [23:0] last_l, last_r;
    void'($urandom(32'd4711));
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R1
    rd(6'h04, v); chk(v == 0, "R1 reset ctrl", v, 0);
    rd(6'h08, v); chk(v == 32'd64, "R1 reset status", v, 64);
    chk(drq == 0 && vld == 0, "R4 reset drq/vld", {drq, vld}, 0);

    // register readback, R1
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); chk(v == 32'hE560_3F70, "R1 ctrl readback", v, 32'hE560_3F70);
    rd(6'h0C, v); chk(v == 0, "R1 data port reads 0", v, 0);
    rd(6'h00, v); chk(v == 0, "R1 unmapped reads 0", v, 0);
    wr(6'h04, 32'h1);

    // frame period per rate code, R6
    for (int c = 0; c < 8; c++) begin
      int n;
      wr(6'h04, 32'(c) << 29);
      wait_vld(); wait_vld();
      @(negedge clk);
      chk(vld == 0, "R6 strobe one cycle", 32'(vld), 0);
      n = 1;
      while (!vld && n < 4000) begin @(negedge clk); n++; end
      chk(n == exp_div(c), "R6 period", 32'(n), 32'(exp_div(c)));
    end

    // DMA request hysteresis, R3 R4 R5 R2 (rate 5, mono 16-bit)
    wr(6'h04, (32'd5 << 29) | 32'h40);
    wait_vld();
    cfg = (32'd5 << 29) | 32'h40;
    wr(6'h04, cfg | 32'h1);
    push(44);
    rd(6'h08, v); chk(v[6:0] == 20, "R3 free after pushes", v, 20);
    chk(drq == 0, "R5 drq off when disabled", 32'(drq), 0);
    wr(6'h04, cfg | 32'h10 | (32'd40 << 8) | (32'd1 << 21));
    @(negedge clk); chk(drq == 0, "R5 between thresholds stays low", 32'(drq), 0);
    wr(6'h04, cfg | 32'h10 | (32'd10 << 8) | (32'd1 << 21));
    @(negedge clk); chk(drq == 1, "R4 assert above trigger", 32'(drq), 1);
    wr(6'h04, cfg | 32'h10 | (32'd40 << 8) | (32'd1 << 21));
    @(negedge clk); chk(drq == 1, "R5 between thresholds stays high", 32'(drq), 1);
    push(13);
    @(negedge clk); chk(drq == 0, "R5 clear below 8", 32'(drq), 0);
    push(8);
    rd(6'h08, v); chk(v[6:0] == 0, "R3 write when full dropped", v, 0);
    wr(6'h04, cfg | 32'h10 | (32'd40 << 8) | (32'd1 << 21) | 32'h1);
    rd(6'h08, v); chk(v[6:0] == 64, "R2 flush empties", v, 64);
    @(negedge clk); chk(drq == 1, "R4 assert after flush", 32'(drq), 1);

    // random frames with directed underrun after each batch
    last_l = '0; last_r = '0;
    for (int it = 0; it < 14; it++) begin
      bit wide, mono, rep, hold;
      int code, nfr;
      string tag;
      wide = 1'($urandom); mono = 1'($urandom);
      rep  = 1'($urandom); hold = 1'($urandom);
      if (it < 4) begin wide = it[1]; mono = it[0]; end
      case ($urandom % 3) 0: code = 6; 1: code = 7; default: code = 0; endcase
      nfr = 1 + ($urandom % 5);
      cfg = (32'(code) << 29) | (32'(hold) << 26) | (32'(rep) << 24)
          | (32'(mono) << 6) | (32'(wide) << 5);
      tag = wide ? "R9" : (mono ? "R10" : (rep ? "R8" : "R7"));
      wait_vld();
      wr(6'h04, cfg | 32'h1);
      wr(6'h08, 32'h100);
      for (int f = 0; f < nfr; f++) begin
        w0 = $urandom; w1 = $urandom;
        wr(6'h0C, w0);
        if (wide && !mono) begin
          wr(6'h0C, w1);
          el[f] = w0[31:8]; er[f] = w1[31:8];
        end else if (wide) begin
          el[f] = w0[31:8]; er[f] = w0[31:8];
        end else if (mono) begin
          el[f] = widen(w0[15:0], rep); er[f] = el[f];
        end else begin
          el[f] = widen(w0[15:0], rep); er[f] = widen(w0[31:16], rep);
        end
      end
      for (int f = 0; f < nfr; f++) begin
        wait_vld();
        chk(sl == el[f], {tag, " left"}, 32'(sl), 32'(el[f]));
        chk(sr == er[f], {tag, " right"}, 32'(sr), 32'(er[f]));
      end
      last_l = el[nfr-1]; last_r = er[nfr-1];
      wait_vld();
      if (hold)
        chk(sl == last_l && sr == last_r, "R12 underrun repeats last",
            {8'h0, sl}, {8'h0, last_l});
      else
        chk(sl == 0 && sr == 0, "R11 underrun outputs zero", {8'h0, sl | sr}, 0);
      rd(6'h08, v); chk(v[8] == 1, "R11 underrun flag set", v, 32'h100);
      wr(6'h08, 32'h100);
      rd(6'h08, v); chk(v[8] == 0, "R13 flag cleared by W1C", v, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule